// File: doc/BRIEF.md
# Multi-Function Pad Multiplexer Cell

This cell sits between one external pad and up to eight on-chip peripherals. A 16-bit configuration register picks which peripheral's output and output-enable pair drives the pad. The pad's input value is handed back to the selected peripheral only. The same register sets the pull-up and pull-down enables. As an alternative, bit 15 lets the selected peripheral request the pulls itself. The register also stores a three-bit drive-strength code, which is presented on an output and not otherwise used.

When the chip is in a low-power state and bit 9 is set, the register takes over the pad. Bit 8 gives the level the pad is driven to, and bit 7 gives an active-low output enable. The pad input passes through a two-flop synchronizer and then feeds an edge detector. An enabled rising or falling edge sets a sticky flag, which is presented as the wake request. Setting bit 6 clears the flag and keeps it clear.

Software programs the cell through a single-register write port with a read-back path. There is no address decode.

Top module: `pinMuxCell`

## Requirements
- R1: After reset, the configuration reads as zero, the wake output is low, and the pad follows peripheral 0's output and output-enable.
- R2: Configuration bits 2:0 hold the function number n (0..7). padOut equals periphOut[n] and padOe equals periphOe[n]. periphIn[n] equals padIn, and every other periphIn bit is 0.
- R3: When sleepMode is 1 and bit 9 is 1, padOut equals bit 8 and padOe equals the inverse of bit 7. Bit 7 is an active-low enable.
- R4: When sleepMode is 0, or when bit 9 is 0, padOut and padOe come from the selected peripheral pair, whatever the values of bits 7 and 8.
- R5: With bit 15 at 0, pullUpEn equals bit 14 and pullDnEn equals bit 13. With bit 15 at 1, pullUpEn equals periphPullUp[n] and pullDnEn equals periphPullDn[n].
- R6: driveCode always equals configuration bits 12:10, unchanged.
- R7: A write stores wrData bits 15:0 except bit 3. Bit 3 and bits 31:16 always read as 0, and writes to them are ignored. Without a write, the register holds its value.
- R8: With bit 4 at 1 and bit 6 at 0, a 0-to-1 change on padIn sets the wake output on the third rising clock edge after the change (two synchronizer stages plus one history stage). With bit 4 at 0, a rising pad edge does not set the wake output.
- R9: With bit 5 at 1 and bit 6 at 0, a 1-to-0 change on padIn sets the wake output on the third rising clock edge after the change. With bit 5 at 0, a falling pad edge does not set the wake output.
- R10: Once set, the wake output stays high through further pad activity and through configuration writes that leave bit 6 at 0.
- R11: While bit 6 is 1, the wake output is cleared on the next clock edge and stays low, and enabled edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read-back |
| sleepMode | input | 1 | Chip low-power state indicator |
| periphOut | input | 8 | Output value of each peripheral function |
| periphOe | input | 8 | Output enable of each peripheral function |
| periphPullUp | input | 8 | Pull-up request of each peripheral function |
| periphPullDn | input | 8 | Pull-down request of each peripheral function |
| periphIn | output | 8 | Pad input returned to the selected function |
| padOut | output | 1 | Value driven to the pad |
| padOe | output | 1 | Pad output enable |
| padIn | input | 1 | Value sensed at the pad |
| pullUpEn | output | 1 | Pull-up enable to the pad |
| pullDnEn | output | 1 | Pull-down enable to the pad |
| driveCode | output | 3 | Stored drive-strength and slew code |
| wakeEvent | output | 1 | Sticky edge-detected wake request |

## Verification
The assertions check on every cycle that:
- the low-power override drives the pad from bits 8 and 7;
- driveCode tracks the register;
- reserved bits read as zero;
- an unwritten register holds its value;
- the wake flag stays set until bit 6 clears it, and bit 6 forces it low on the next edge;
- the flag only rises while some edge enable is set.

Only the bench scenarios can show a set of timing and selection facts. These are:
- the exact three-edge latency from a pad transition to the wake output;
- that a disabled edge direction is ignored;
- that the selected function alone receives the pad input;
- the full routing of the function mux and the pull sources under random configurations.

// File: rtl/pinMuxPkg.sv
package pinMuxPkg;
  localparam int NUM_FUNC  = 8;
  localparam int SEL_W     = $clog2(NUM_FUNC);
  localparam int CFG_W     = 16;
  localparam int REG_W     = 32;
  localparam int DRIVE_W   = 3;
  localparam int SYNC_STAGES = 2;

  // Bit positions inside the configuration register
  localparam int B_RISE   = 4;
  localparam int B_FALL   = 5;
  localparam int B_CLR    = 6;
  localparam int B_OVR_OEN = 7;
  localparam int B_OVR_DAT = 8;
  localparam int B_OVR_SEL = 9;
  localparam int B_DRV_LO = 10;
  localparam int B_PULL_DN = 13;
  localparam int B_PULL_UP = 14;
  localparam int B_PULL_FN = 15;

  localparam logic [CFG_W-1:0] WR_MASK = 16'hFFF7;

  typedef struct packed {
    logic [SEL_W-1:0]   funcSel;
    logic               riseEn;
    logic               fallEn;
    logic               edgeClr;
    logic               ovrOeN;
    logic               ovrData;
    logic               ovrSel;
    logic [DRIVE_W-1:0] drive;
    logic               pullDn;
    logic               pullUp;
    logic               pullFromFunc;
  } pinCtrlT;
endpackage

// File: rtl/pinCfgCtrl.sv
module pinCfgCtrl
  import pinMuxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output pinCtrlT          ctrl
);
  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgQ <= '0;
    else if (wrEn) cfgQ <= wrData[CFG_W-1:0] & WR_MASK;
  end

  assign rdData = {{(REG_W-CFG_W){1'b0}}, cfgQ};

  always_comb begin
    ctrl.funcSel      = cfgQ[SEL_W-1:0];
    ctrl.riseEn       = cfgQ[B_RISE];
    ctrl.fallEn       = cfgQ[B_FALL];
    ctrl.edgeClr      = cfgQ[B_CLR];
    ctrl.ovrOeN       = cfgQ[B_OVR_OEN];
    ctrl.ovrData      = cfgQ[B_OVR_DAT];
    ctrl.ovrSel       = cfgQ[B_OVR_SEL];
    ctrl.drive        = cfgQ[B_DRV_LO +: DRIVE_W];
    ctrl.pullDn       = cfgQ[B_PULL_DN];
    ctrl.pullUp       = cfgQ[B_PULL_UP];
    ctrl.pullFromFunc = cfgQ[B_PULL_FN];
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
endmodule

// File: rtl/pinEdgeWake.sv
module pinEdgeWake
  import pinMuxPkg::*;
#(
  parameter int STAGES = SYNC_STAGES
)(
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  input  logic riseEn,
  input  logic fallEn,
  input  logic edgeClr,
  output logic wake
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chainQ;
  logic newV, oldV, riseHit, fallHit;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chainQ[g] <= 1'b0;
          else       chainQ[g] <= padIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chainQ[g] <= 1'b0;
          else       chainQ[g] <= chainQ[g-1];
      end
    end
  endgenerate

  assign newV    = chainQ[STAGES-1];
  assign oldV    = chainQ[STAGES];
  assign riseHit = riseEn & newV & ~oldV;
  assign fallHit = fallEn & ~newV & oldV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    wake <= 1'b0;
    else if (edgeClr)             wake <= 1'b0;
    else if (riseHit || fallHit)  wake <= 1'b1;
  end

  // R11
  clr_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeClr |=> !wake);
  // R10
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wake && !edgeClr) |=> wake);
  // R8
  wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wake) |-> $past(riseEn || fallEn));
endmodule

// File: rtl/pinMuxPath.sv
module pinMuxPath
  import pinMuxPkg::*;
(
  input  pinCtrlT             ctrl,
  input  logic                sleepMode,
  input  logic [NUM_FUNC-1:0] periphOut,
  input  logic [NUM_FUNC-1:0] periphOe,
  input  logic [NUM_FUNC-1:0] periphPullUp,
  input  logic [NUM_FUNC-1:0] periphPullDn,
  output logic [NUM_FUNC-1:0] periphIn,
  input  logic                padIn,
  output logic                padOut,
  output logic                padOe,
  output logic                pullUpEn,
  output logic                pullDnEn,
  output logic [DRIVE_W-1:0]  driveCode
);
  logic useOvr;
  logic fnOut, fnOe, fnUp, fnDn;

  assign useOvr = sleepMode & ctrl.ovrSel;
  assign fnOut  = periphOut[ctrl.funcSel];
  assign fnOe   = periphOe[ctrl.funcSel];
  assign fnUp   = periphPullUp[ctrl.funcSel];
  assign fnDn   = periphPullDn[ctrl.funcSel];

  always_comb begin
    if (useOvr) begin
      padOut = ctrl.ovrData;
      padOe  = ~ctrl.ovrOeN;
    end else begin
      padOut = fnOut;
      padOe  = fnOe;
    end
    pullUpEn = ctrl.pullFromFunc ? fnUp : ctrl.pullUp;
    pullDnEn = ctrl.pullFromFunc ? fnDn : ctrl.pullDn;
  end

  genvar f;
  generate
    for (f = 0; f < NUM_FUNC; f++) begin : gRet
      assign periphIn[f] = (ctrl.funcSel == SEL_W'(f)) ? padIn : 1'b0;
    end
  endgenerate

  assign driveCode = ctrl.drive;
endmodule

// File: rtl/pinMuxCell.sv
module pinMuxCell
  import pinMuxPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [REG_W-1:0]    cfgWdata,
  output logic [REG_W-1:0]    cfgRdata,
  input  logic                sleepMode,
  input  logic [NUM_FUNC-1:0] periphOut,
  input  logic [NUM_FUNC-1:0] periphOe,
  input  logic [NUM_FUNC-1:0] periphPullUp,
  input  logic [NUM_FUNC-1:0] periphPullDn,
  output logic [NUM_FUNC-1:0] periphIn,
  output logic                padOut,
  output logic                padOe,
  input  logic                padIn,
  output logic                pullUpEn,
  output logic                pullDnEn,
  output logic [DRIVE_W-1:0]  driveCode,
  output logic                wakeEvent
);
  pinCtrlT ctrl;

  pinCfgCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWe), .wrData(cfgWdata),
    .rdData(cfgRdata), .ctrl(ctrl)
  );

  pinMuxPath uPath (
    .ctrl(ctrl), .sleepMode(sleepMode),
    .periphOut(periphOut), .periphOe(periphOe),
    .periphPullUp(periphPullUp), .periphPullDn(periphPullDn),
    .periphIn(periphIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn), .driveCode(driveCode)
  );

  pinEdgeWake #(.STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .padIn(padIn),
    .riseEn(ctrl.riseEn), .fallEn(ctrl.fallEn), .edgeClr(ctrl.edgeClr),
    .wake(wakeEvent)
  );

  // R3
  sleep_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && cfgRdata[B_OVR_SEL]) |->
      (padOut == cfgRdata[B_OVR_DAT] && padOe == !cfgRdata[B_OVR_OEN]));
  // R6
  drive_export_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveCode == cfgRdata[B_DRV_LO +: DRIVE_W]);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[REG_W-1:CFG_W] == '0 && !cfgRdata[3]);
endmodule

// File: tb/sim_pinMuxCell.sv
`timescale 1ns/1ps
module sim_pinMuxCell;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0, cfgRdata;
  logic sleepMode = 1'b0;
  logic [7:0] periphOut = '0, periphOe = '0, periphPullUp = '0, periphPullDn = '0;
  logic [7:0] periphIn;
  logic padOut, padOe, padIn = 1'b0, pullUpEn, pullDnEn, wakeEvent;
  logic [2:0] driveCode;
  int nChecks = 0, nFails = 0, cycles = 0;
  logic [31:0] shadow = '0;

  always #4 clk = ~clk;

  pinMuxCell u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0; cfgWdata = $urandom;
    shadow = v & 32'h0000_FFF7;
  endtask

  function automatic logic [1:0] expPad(input logic [31:0] c, input logic slp,
                                         input logic [7:0] o, input logic [7:0] e);
    if (slp && c[9]) return {c[8], ~c[7]};
    return {o[c[2:0]], e[c[2:0]]};
  endfunction

  function automatic logic [1:0] expPull(input logic [31:0] c, input logic [7:0] u,
                                          input logic [7:0] d);
    if (c[15]) return {u[c[2:0]], d[c[2:0]]};
    return {c[14], c[13]};
  endfunction

  task automatic checkComb(input string tag);
    #1;
    check({tag, " R2/R3/R4 pad"}, {padOut, padOe}, expPad(shadow, sleepMode, periphOut, periphOe));
    check({tag, " R5 pulls"}, {pullUpEn, pullDnEn}, expPull(shadow, periphPullUp, periphPullDn));
    check({tag, " R6 drive"}, driveCode, shadow[12:10]);
    check({tag, " R2 periphIn"}, periphIn, padIn ? (8'd1 << shadow[2:0]) : 8'd0);
    check({tag, " R7 readback"}, cfgRdata, shadow);
  endtask

  task automatic movePad(input logic v);
    @(negedge clk); padIn = v;
  endtask

  initial begin
    void'($urandom(32'd4242));
    periphOut = 8'hA5; periphOe = 8'h3C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 cfg", cfgRdata, 32'd0);
    check("R1 wake", wakeEvent, 1'b0);
    check("R1 pad", {padOut, padOe}, {periphOut[0], periphOe[0]});

    // R7 reserved bits dropped
    writeCfg(32'hFFFF_000F);
    check("R7 reserved", cfgRdata, 32'h0000_0007);
    // R7 hold without write
    cfgWdata = 32'h0000_1234; repeat (2) @(negedge clk); #1;
    check("R7 hold", cfgRdata, 32'h0000_0007);

    // R3 override, R4 no override when sleep low
    writeCfg(32'h0000_0300 | 32'h2); // bit9, bit8 set, bit7 clear -> oe 1
    sleepMode = 1'b1; checkComb("dir-sleep");
    check("R3 override", {padOut, padOe}, 2'b11);
    sleepMode = 1'b0; checkComb("dir-awake");
    check("R4 no override", {padOut, padOe}, {periphOut[2], periphOe[2]});

    // Random sweep
    for (int i = 0; i < 300; i++) begin
      writeCfg($urandom & 32'hFFFF_FFBF);
      periphOut = $urandom; periphOe = $urandom;
      periphPullUp = $urandom; periphPullDn = $urandom;
      sleepMode = $urandom; padIn = $urandom;
      checkComb("rand");
    end
    movePad(1'b0); repeat (4) @(negedge clk);

    // R8 rising edge, latency
    writeCfg(32'h0000_0040); writeCfg(32'h0000_0010);
    movePad(1'b1);
    @(negedge clk); @(negedge clk); #1;
    check("R8 no early wake", wakeEvent, 1'b0);
    @(negedge clk); #1;
    check("R8 rise wake", wakeEvent, 1'b1);
    // R10 sticky across pad activity and writes without bit6
    movePad(1'b0); repeat (4) @(negedge clk);
    writeCfg(32'h0000_0000); #1;
    check("R10 sticky", wakeEvent, 1'b1);
    // R11 clear and hold clear
    writeCfg(32'h0000_0070); @(negedge clk); #1;
    check("R11 cleared", wakeEvent, 1'b0);
    movePad(1'b1); repeat (5) @(negedge clk);
    movePad(1'b0); repeat (5) @(negedge clk); #1;
    check("R11 edges ignored", wakeEvent, 1'b0);

    // R8 disabled rise ignored (fall enabled only)
    writeCfg(32'h0000_0020);
    movePad(1'b1); repeat (5) @(negedge clk); #1;
    check("R8 rise disabled", wakeEvent, 1'b0);
    // R9 fall edge, latency
    movePad(1'b0);
    @(negedge clk); @(negedge clk); #1;
    check("R9 no early wake", wakeEvent, 1'b0);
    @(negedge clk); #1;
    check("R9 fall wake", wakeEvent, 1'b1);
    // R9 disabled fall ignored
    writeCfg(32'h0000_0040); writeCfg(32'h0000_0010);
    movePad(1'b1); repeat (5) @(negedge clk);
    writeCfg(32'h0000_0040); writeCfg(32'h0000_0010);
    movePad(1'b0); repeat (5) @(negedge clk); #1;
    check("R9 fall disabled", wakeEvent, 1'b0);

    finishRun();
  end
endmodule